// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one bus transfer at a time on a 16-bit bus where address and data share the same lines. A transfer can be a memory or I/O access, and a read or a write. The client raises `req` for one clock while the sequencer is idle, with the direction, space, 20-bit address, write data and high-byte flag. The sequencer stores these values and then steps through a fixed set of clock-long phases. The address goes out first, together with a latch pulse for external latches. Next come the data phases, which the slave can lengthen by holding `mem_ready` low. A closing phase ends the transfer and signals completion.

The states are IDLE, T1, T2, T3, TW and T4. The transitions are:
- IDLE→T1 on an accepted request.
- T1→T2 and T2→T3 unconditionally.
- T3→T4 or TW→T4 when `mem_ready` is sampled high.
- T3→TW or TW→TW when `mem_ready` is sampled low.
- T4→IDLE unconditionally.

A synchronous reset forces IDLE from any state.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and in IDLE, the outputs take these values: `addr_latch_en`=0, `rd_strb_n`=1, `wr_strb_n`=1, `xcvr_en_n`=1, `ad_oe`=0, `ad_out`=0, `hi_addr_stat`=0, `mem_sel`=0, `xcvr_dir`=0, `hi_byte_n`=1 and `done`=0. After reset, `rd_data` is 0.
- R2: A request sampled in IDLE starts T1 at the next edge. The cycle then runs T1, T2, T3, zero or more TW, T4, and then returns to IDLE.
- R3: In T1, `addr_latch_en` is 1, `ad_oe` is 1, `ad_out` equals address bits 15..0 and `hi_addr_stat` equals address bits 19..16. `addr_latch_en` is 0 in every other state.
- R4: From T2 through T4, `hi_addr_stat` carries status rather than address. Bit 3 is 1, bit 2 is 0, bit 1 is the memory flag and bit 0 is the write flag.
- R5: For a read, `rd_strb_n` is 0 in T2, T3 and every TW, and 1 otherwise. From T2 through T4, `ad_oe` is 0 and `ad_out` is 0.
- R6: For a write, `wr_strb_n` is 0 in T2, T3 and every TW. From T2 through T4, `ad_oe` is 1 and `ad_out` holds the write data stored at acceptance.
- R7: `xcvr_en_n` is 0 in T2, T3 and every TW, and 1 in T1, T4 and IDLE.
- R8: From T1 through T4, `mem_sel` equals the stored memory flag (1 = memory), `xcvr_dir` equals the stored write flag (0 = receive, 1 = transmit) and `hi_byte_n` is the inverse of the stored high-byte flag. In IDLE these outputs are 0, 0 and 1.
- R9: `mem_ready` is sampled at the edge that ends T3 and at the edge that ends each TW. A low sample enters or stays in TW, and a high sample enters T4.
- R10: On a read, `rd_data` takes `ad_in` at the edge where `mem_ready` is sampled high. It holds that value through later write cycles until the next read captures new data.
- R11: `done` is 1 for exactly the single T4 cycle.
- R12: A request seen outside IDLE is ignored. The cycle in flight is unchanged, and the sequencer returns to IDLE afterwards with no new T1.
- R13: A synchronous reset in the middle of a cycle returns the sequencer to IDLE at the next edge, with the R1 output values and `rd_data` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per bus state |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Start a transfer (accepted in IDLE only) |
| is_write | input | 1 | 1 = write, 0 = read |
| is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| addr | input | 20 | Transfer address |
| wdata | input | 16 | Write data |
| req_hi_byte | input | 1 | Transfer uses the upper byte lane |
| mem_ready | input | 1 | Slave ready; low inserts wait states |
| ad_in | input | 16 | Value seen on the shared lines |
| addr_latch_en | output | 1 | Address latch pulse in T1 |
| rd_strb_n | output | 1 | Read strobe, active low |
| wr_strb_n | output | 1 | Write strobe, active low |
| mem_sel | output | 1 | Memory (1) / I/O (0) select |
| xcvr_dir | output | 1 | Transceiver direction, 1 = transmit |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| hi_addr_stat | output | 4 | Upper address in T1, status afterwards |
| hi_byte_n | output | 1 | Upper byte lane enable, active low |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse in T4 |

## Verification
Two events can fall on the same clock edge: the final `mem_ready` sample that releases the wait loop, and the capture of read data. The bench keeps `ad_in` at a wrong value in every cycle except the one whose closing edge sees `mem_ready` high. It does this for zero, one and several wait states. A capture one edge early or one edge late would then latch the wrong word, and the per-cycle model flags it in T4. A second overlap is a new request arriving while a cycle is in flight. The bench raises `req` during T2 and checks that the cycle finishes unchanged and that no T1 follows.

// File: rtl/busseq_pkg.sv
`timescale 1ns/1ps
package busseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_T3   = 3'd3,
        S_TW   = 3'd4,
        S_T4   = 3'd5
    } bus_state_t;
endpackage

// File: rtl/busseq_fsm.sv
`timescale 1ns/1ps
module busseq_fsm
    import busseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       mem_ready,
    output bus_state_t state,
    output logic       launch,
    output logic       sample_hit
);
    bus_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req) nxt = S_T1;
            S_T1:   nxt = S_T2;
            S_T2:   nxt = S_T3;
            S_T3:   nxt = mem_ready ? S_T4 : S_TW;
            S_TW:   nxt = mem_ready ? S_T4 : S_TW;
            S_T4:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign launch     = (state == S_IDLE) && req;
    assign sample_hit = ((state == S_T3) || (state == S_TW)) && mem_ready;

    // R9
    wait_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == S_T3) && !mem_ready) |=> (state == S_TW));

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> (state != S_T1));

    // R2
    t4_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_T4) |=> (state == S_IDLE));
endmodule

// File: rtl/busseq_latch.sv
`timescale 1ns/1ps
module busseq_latch #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              sample_hit,
    input  logic              is_write,
    input  logic              is_mem,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              req_hi_byte,
    input  logic [DATA_W-1:0] ad_in,
    output logic              wr_q,
    output logic              mem_q,
    output logic              hib_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            mem_q   <= 1'b0;
            hib_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (launch) begin
            wr_q    <= is_write;
            mem_q   <= is_mem;
            hib_q   <= req_hi_byte;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     rd_data <= '0;
        else if (sample_hit && !wr_q) rd_data <= ad_in;
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_hit |=> $stable(rd_data));
endmodule

// File: rtl/busseq_drive.sv
`timescale 1ns/1ps
module busseq_drive
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_t        state,
    input  logic              wr_q,
    input  logic              mem_q,
    input  logic              hib_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic              addr_latch_en,
    output logic              rd_strb_n,
    output logic              wr_strb_n,
    output logic              mem_sel,
    output logic              xcvr_dir,
    output logic              xcvr_en_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   hi_addr_stat,
    output logic              hi_byte_n,
    output logic              done
);
    logic [HI_W-1:0] stat_word;

    always_comb begin
        stat_word         = '0;
        stat_word[HI_W-1] = 1'b1;
        stat_word[1]      = mem_q;
        stat_word[0]      = wr_q;
    end

    always_comb begin
        addr_latch_en = 1'b0;
        rd_strb_n     = 1'b1;
        wr_strb_n     = 1'b1;
        mem_sel       = 1'b0;
        xcvr_dir      = 1'b0;
        xcvr_en_n     = 1'b1;
        ad_out        = '0;
        ad_oe         = 1'b0;
        hi_addr_stat  = '0;
        hi_byte_n     = 1'b1;
        done          = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_T1: begin
                addr_latch_en = 1'b1;
                mem_sel       = mem_q;
                xcvr_dir      = wr_q;
                hi_byte_n     = !hib_q;
                ad_oe         = 1'b1;
                ad_out        = addr_q[DATA_W-1:0];
                hi_addr_stat  = addr_q[ADDR_W-1:DATA_W];
            end
            S_T2, S_T3, S_TW: begin
                mem_sel      = mem_q;
                xcvr_dir     = wr_q;
                hi_byte_n    = !hib_q;
                hi_addr_stat = stat_word;
                xcvr_en_n    = 1'b0;
                rd_strb_n    = wr_q;
                wr_strb_n    = !wr_q;
                ad_oe        = wr_q;
                ad_out       = wr_q ? wdata_q : '0;
            end
            S_T4: begin
                mem_sel      = mem_q;
                xcvr_dir     = wr_q;
                hi_byte_n    = !hib_q;
                hi_addr_stat = stat_word;
                ad_oe        = wr_q;
                ad_out       = wr_q ? wdata_q : '0;
                done         = 1'b1;
            end
            default: ;
        endcase
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rd_strb_n || wr_strb_n);

    // R3
    ale_single_chk: assert property (@(posedge clk) disable iff (rst)
        addr_latch_en |=> !addr_latch_en);

    // R5
    rd_after_ale_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_strb_n) |-> $past(addr_latch_en));

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_strb_n |-> !ad_oe);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic                     is_write,
    input  logic                     is_mem,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     req_hi_byte,
    input  logic                     mem_ready,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     addr_latch_en,
    output logic                     rd_strb_n,
    output logic                     wr_strb_n,
    output logic                     mem_sel,
    output logic                     xcvr_dir,
    output logic                     xcvr_en_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_addr_stat,
    output logic                     hi_byte_n,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     done
);
    bus_state_t        state;
    logic              launch, sample_hit;
    logic              wr_q, mem_q, hib_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    busseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .mem_ready  (mem_ready),
        .state      (state),
        .launch     (launch),
        .sample_hit (sample_hit)
    );

    busseq_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .sample_hit  (sample_hit),
        .is_write    (is_write),
        .is_mem      (is_mem),
        .addr        (addr),
        .wdata       (wdata),
        .req_hi_byte (req_hi_byte),
        .ad_in       (ad_in),
        .wr_q        (wr_q),
        .mem_q       (mem_q),
        .hib_q       (hib_q),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .rd_data     (rd_data)
    );

    busseq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk           (clk),
        .rst           (rst),
        .state         (state),
        .wr_q          (wr_q),
        .mem_q         (mem_q),
        .hib_q         (hib_q),
        .addr_q        (addr_q),
        .wdata_q       (wdata_q),
        .addr_latch_en (addr_latch_en),
        .rd_strb_n     (rd_strb_n),
        .wr_strb_n     (wr_strb_n),
        .mem_sel       (mem_sel),
        .xcvr_dir      (xcvr_dir),
        .xcvr_en_n     (xcvr_en_n),
        .ad_out        (ad_out),
        .ad_oe         (ad_oe),
        .hi_addr_stat  (hi_addr_stat),
        .hi_byte_n     (hi_byte_n),
        .done          (done)
    );
endmodule

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        is_write = 1'b0;
    logic        is_mem = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        req_hi_byte = 1'b0;
    logic        mem_ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic        addr_latch_en, rd_strb_n, wr_strb_n, mem_sel, xcvr_dir, xcvr_en_n;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  hi_addr_stat;
    logic        hi_byte_n;
    logic [15:0] rd_data;
    logic        done;

    int tests = 0;
    int fails = 0;
    logic [15:0] last_rd = '0;

    always #4 clk = ~clk;

    bus_cycle_seq u_dut (
        .clk(clk), .rst(rst), .req(req), .is_write(is_write), .is_mem(is_mem),
        .addr(addr), .wdata(wdata), .req_hi_byte(req_hi_byte), .mem_ready(mem_ready),
        .ad_in(ad_in), .addr_latch_en(addr_latch_en), .rd_strb_n(rd_strb_n),
        .wr_strb_n(wr_strb_n), .mem_sel(mem_sel), .xcvr_dir(xcvr_dir),
        .xcvr_en_n(xcvr_en_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .hi_addr_stat(hi_addr_stat), .hi_byte_n(hi_byte_n), .rd_data(rd_data),
        .done(done)
    );

    // phase: 0 idle, 1 address, 2 first data, 3 second data, 4 wait, 5 closing
    task automatic cmp_phase(input int ph, input bit w, input bit m, input logic [19:0] a,
                             input logic [15:0] wd, input bit hb, input string tag);
        logic [28:0] got, exp;
        bit busy, strobe, drive;
        busy   = (ph != 0);
        strobe = (ph >= 2) && (ph <= 4);
        drive  = (ph == 1) || (w && ph >= 2);
        exp[28] = (ph == 1);
        exp[27] = !(strobe && !w);
        exp[26] = !(strobe && w);
        exp[25] = !strobe;
        exp[24] = busy ? m : 1'b0;
        exp[23] = busy ? w : 1'b0;
        exp[22] = drive;
        exp[21] = busy ? !hb : 1'b1;
        exp[20] = (ph == 5);
        exp[19:16] = (ph == 1) ? a[19:16] : (ph >= 2) ? {1'b1, 1'b0, m, w} : 4'h0;
        exp[15:0]  = (ph == 1) ? a[15:0] : (w && ph >= 2) ? wd : 16'h0;
        got = {addr_latch_en, rd_strb_n, wr_strb_n, xcvr_en_n, mem_sel, xcvr_dir,
               ad_oe, hi_byte_n, done, hi_addr_stat, ad_out};
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s phase %0d: got %h expected %h", tag, ph, got, exp);
        end
    endtask

    task automatic chk_rd(input logic [15:0] e, input string tag);
        tests++;
        if (rd_data !== e) begin
            fails++;
            $display("FAIL %s rd_data: got %h expected %h", tag, rd_data, e);
        end
    endtask

    task automatic run_bus(input bit w, input bit m, input logic [19:0] a,
                           input logic [15:0] wd, input bit hb, input int nwait,
                           input logic [15:0] rv, input bit poke_busy, input string tag);
        int ph;
        @(negedge clk);
        req = 1'b1; is_write = w; is_mem = m; addr = a; wdata = wd;
        req_hi_byte = hb; mem_ready = 1'b1; ad_in = 16'hDEAD;
        @(negedge clk);
        req = 1'b0; addr = ~a; wdata = ~wd; is_write = !w; is_mem = !m; req_hi_byte = !hb;
        for (int k = 1; k <= 4 + nwait; k++) begin
            if (k > 1) @(negedge clk);
            ph = (k <= 3) ? k : (k <= 3 + nwait) ? 4 : 5;
            cmp_phase(ph, w, m, a, wd, hb, tag);
            if (ph == 5) begin
                if (!w) last_rd = rv;
                chk_rd(last_rd, "R10");
            end
            if (ph == 3 || ph == 4) begin
                mem_ready = (k - 3 >= nwait);
                ad_in = mem_ready ? rv : (16'hBAD0 + 16'(k));
            end else begin
                mem_ready = 1'b1;
                ad_in = 16'hDEAD;
            end
            if (poke_busy) begin
                req  = (k == 2) || (k == 3 + nwait);
                addr = 20'h0F0F0;
            end
        end
        req = 1'b0;
        @(negedge clk);
        cmp_phase(0, w, m, a, wd, hb, poke_busy ? "R12" : "R2");
        @(negedge clk);
        cmp_phase(0, w, m, a, wd, hb, poke_busy ? "R12" : "R2");
        chk_rd(last_rd, "R10");
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_phase(0, 0, 0, '0, '0, 0, "R1");
        chk_rd(16'h0, "R1");
        rst = 1'b0;
        @(negedge clk);
        cmp_phase(0, 0, 0, '0, '0, 0, "R1");

        // R2 R3 R5 R7 R8: memory read, no waits
        run_bus(0, 1, 20'hA1234, 16'h0, 1, 0, 16'h5A5A, 0, "R5");
        // R6 R4: I/O write, no waits
        run_bus(1, 0, 20'h3FFE0, 16'hC3C3, 0, 0, 16'h0, 0, "R6");
        // R9 R10: read with one wait
        run_bus(0, 0, 20'h0FFE4, 16'h0, 0, 1, 16'h1357, 0, "R9");
        // R9: write with three waits
        run_bus(1, 1, 20'hF8000, 16'h8001, 1, 3, 16'h0, 0, "R9");
        // R10: read with five waits
        run_bus(0, 1, 20'hFFFF0, 16'h0, 1, 5, 16'hBEEF, 0, "R10");
        // R12: request poked while busy
        run_bus(0, 1, 20'h12345, 16'h0, 0, 2, 16'h2468, 1, "R12");
        run_bus(1, 0, 20'h00001, 16'hFFFF, 1, 0, 16'h0, 1, "R12");

        // R13: reset in the middle of a read cycle
        @(negedge clk);
        req = 1'b1; is_write = 1'b0; is_mem = 1'b1; addr = 20'h55555; mem_ready = 1'b1;
        @(negedge clk);
        req = 1'b0;
        cmp_phase(1, 0, 1, 20'h55555, 16'h0, 0, "R13");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cmp_phase(0, 0, 0, '0, '0, 0, "R13");
        last_rd = 16'h0;
        chk_rd(16'h0, "R13");
        @(negedge clk);
        cmp_phase(0, 0, 0, '0, '0, 0, "R13");
        run_bus(0, 0, 20'h00ABC, 16'h0, 0, 0, 16'h7E7E, 0, "R13");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule